// File: doc/BRIEF.md
# Scatter-Gather DMA Register and Interrupt Front End

This block is the software-visible front end of a memory-to-memory scatter-gather DMA controller. Software uses a small memory-mapped slave port (address, write strobe, write data, read strobe, read data) to reach three registers: a status word, a control word and the pointer to the first descriptor of a chain. The block gives the descriptor-walking engine a run level, the start pointer and a one-cycle reset pulse. It takes back per-descriptor and end-of-chain event pulses and a live busy level.

Completion flags are cleared by writing 1 to them. The interrupt request is a separate latch with its own clear bit, so clearing the flags does not drop the request. A software reset needs the reset bit written on two register writes in a row. The second write returns every register, the interrupt and the engine to idle.

Reads have one cycle of latency: read data is registered on the edge that samples the read strobe.

Top module: `sgdma_csr`

## Requirements
- R1: After the reset input (active low), all three registers read as zero, apart from the busy bit, which follows the engine. The interrupt output, run level, start pointer and engine reset pulse are all zero.
- R2: Register offsets are 0 = status, 1 = control, 2 = descriptor pointer; offset 3 reads as zero and ignores writes. Read data appears on the cycle after the read strobe and reflects the state before that edge.
- R3: Status bit 0 (descriptor-completed) sets on a descriptor-done pulse and status bit 1 (chain-completed) sets on a chain-done pulse; both stay set until cleared.
- R4: Writing status with a 1 in bit 0 or bit 1 clears that flag, a 0 leaves it unchanged; a done pulse in the same cycle as the clear wins and the flag stays set.
- R5: Status bit 4 reads the engine-busy input as sampled at the read edge.
- R6: Control bit 2 (run) drives the run output, control bits 0 (chain interrupt enable) and 1 (global interrupt enable) read back as written, and the pointer register drives the start-pointer output, all from the edge after the write.
- R7: The interrupt output rises on the edge after a chain-done pulse only if both enables were already set; a descriptor-done pulse never raises it.
- R8: Once raised, the interrupt stays high regardless of status-flag writes until control is written with bit 3 (clear-interrupt) set. Bits 3 and 4 of control always read as 0.
- R9: A control write with bit 4 set, directly following another control write with bit 4 set, zeroes every register and the interrupt on that edge. It also drives the engine reset output high for exactly one cycle.
- R10: Any register write that is not a control write with bit 4 set cancels a pending first reset write. The first reset write applies its other control bits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | ADDR_W | Register offset |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | DATA_W | Write data |
| csr_rd | input | 1 | Read strobe |
| csr_rdata | output | DATA_W | Registered read data |
| eng_run | output | 1 | Run level to the descriptor engine |
| eng_start_ptr | output | PTR_W | First descriptor address |
| eng_reset | output | 1 | One-cycle engine reset pulse |
| desc_done | input | 1 | Descriptor-completed event pulse |
| chain_done | input | 1 | Chain-completed event pulse |
| eng_busy | input | 1 | Engine busy level |
| irq | output | 1 | Level interrupt request |

## Verification
A stuck or lost interrupt latch shows on the irq pin on the edge after the chain-done pulse or the clear write that should have moved it. A corrupted flag shows on the next status read, one cycle later. A wrongly held or dropped reset arm shows on the very next control write with bit 4 set: eng_reset fires or stays low, and the run and pointer outputs jump or stay put on that edge. The bench mixes directed collision, enable and reset-sequence cases with random traffic. It checks every output every cycle against a cycle model.

// File: rtl/sgdma_csr_pkg.sv
`timescale 1ns/1ps
package sgdma_csr_pkg;
    localparam int unsigned OFS_STATUS  = 0;
    localparam int unsigned OFS_CTRL    = 1;
    localparam int unsigned OFS_PTR     = 2;

    localparam int unsigned ST_DESC     = 0;
    localparam int unsigned ST_CHAIN    = 1;
    localparam int unsigned ST_BUSY     = 4;

    localparam int unsigned CT_IE_CHAIN = 0;
    localparam int unsigned CT_IE_GLOB  = 1;
    localparam int unsigned CT_RUN      = 2;
    localparam int unsigned CT_CLR_IRQ  = 3;
    localparam int unsigned CT_SWRST    = 4;

    localparam int unsigned NUM_FLAGS   = 2;

    typedef struct packed {
        logic run;
        logic ie_glob;
        logic ie_chain;
    } ctrl_t;
endpackage

// File: rtl/sgdma_csr_flags.sv
`timescale 1ns/1ps
module sgdma_csr_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } flag_st_t;

    flag_st_t     st_d, st_q;
    logic [N-1:0] nxt;

    // Per-flag next value: an event outranks a same-cycle clear.
    for (genvar gi = 0; gi < N; gi++) begin : g_flag
        assign nxt[gi] = set_i[gi] | (st_q.flag[gi] & ~clr_i[gi]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = soft_rst ? '0 : nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flag;
endmodule

// File: rtl/sgdma_csr_irq.sv
`timescale 1ns/1ps
module sgdma_csr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic chain_evt,
    input  logic en_chain,
    input  logic en_glob,
    input  logic clr,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    raise;

    assign raise = chain_evt & en_chain & en_glob;

    always_comb begin
        st_d = st_q;
        if (soft_rst)    st_d.pend = 1'b0;
        else if (raise)  st_d.pend = 1'b1;
        else if (clr)    st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.pend;
endmodule

// File: rtl/sgdma_csr_swrst.sv
`timescale 1ns/1ps
module sgdma_csr_swrst (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_any,
    input  logic wr_rst_bit,
    output logic fire_o,
    output logic armed_o,
    output logic pulse_o
);
    typedef struct packed {
        logic armed;
        logic pulse;
    } rst_st_t;

    rst_st_t st_d, st_q;
    logic    fire;

    assign fire = wr_rst_bit & st_q.armed;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = fire;
        if (fire)        st_d.armed = 1'b0;
        else if (wr_any) st_d.armed = wr_rst_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o  = fire;
    assign armed_o = st_q.armed;
    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/sgdma_csr.sv
`timescale 1ns/1ps
module sgdma_csr
    import sgdma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_wr,
    input  logic [DATA_W-1:0] csr_wdata,
    input  logic              csr_rd,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              eng_run,
    output logic [PTR_W-1:0]  eng_start_ptr,
    output logic              eng_reset,
    input  logic              desc_done,
    input  logic              chain_done,
    input  logic              eng_busy,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PTR    = ADDR_W'(OFS_PTR);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                 wr_status, wr_ctrl, wr_ptr, wr_ctrl_rst;
    logic                 soft_rst, armed, rst_pulse, irq_w;
    logic [NUM_FLAGS-1:0] flags, flag_set, flag_clr;
    logic [DATA_W-1:0]    status_word, ctrl_word, ptr_word;
    logic                 unused_wdata;

    assign wr_status   = csr_wr && (csr_addr == A_STATUS);
    assign wr_ctrl     = csr_wr && (csr_addr == A_CTRL);
    assign wr_ptr      = csr_wr && (csr_addr == A_PTR);
    assign wr_ctrl_rst = wr_ctrl && csr_wdata[CT_SWRST];

    assign flag_set = {chain_done, desc_done};
    assign flag_clr = {NUM_FLAGS{wr_status}} & csr_wdata[NUM_FLAGS-1:0];

    sgdma_csr_swrst u_swrst (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_any     (csr_wr),
        .wr_rst_bit (wr_ctrl_rst),
        .fire_o     (soft_rst),
        .armed_o    (armed),
        .pulse_o    (rst_pulse)
    );

    sgdma_csr_flags #(.N(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .set_i    (flag_set),
        .clr_i    (flag_clr),
        .flags_o  (flags)
    );

    sgdma_csr_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .chain_evt (chain_done),
        .en_chain  (st_q.ctrl.ie_chain),
        .en_glob   (st_q.ctrl.ie_glob),
        .clr       (wr_ctrl && csr_wdata[CT_CLR_IRQ]),
        .irq_o     (irq_w)
    );

    // Read-back words: write-only control bits are absent and read as 0.
    always_comb begin
        status_word            = '0;
        status_word[ST_DESC]   = flags[0];
        status_word[ST_CHAIN]  = flags[1];
        status_word[ST_BUSY]   = eng_busy;
        ctrl_word              = '0;
        ctrl_word[CT_IE_CHAIN] = st_q.ctrl.ie_chain;
        ctrl_word[CT_IE_GLOB]  = st_q.ctrl.ie_glob;
        ctrl_word[CT_RUN]      = st_q.ctrl.run;
        ptr_word               = DATA_W'(st_q.ptr);
    end

    always_comb begin
        st_d = st_q;
        if (csr_rd) begin
            unique case (csr_addr)
                A_STATUS: st_d.rdata = status_word;
                A_CTRL:   st_d.rdata = ctrl_word;
                A_PTR:    st_d.rdata = ptr_word;
                default:  st_d.rdata = '0;
            endcase
        end
        if (soft_rst) begin
            st_d.ctrl = '0;
            st_d.ptr  = '0;
        end else begin
            if (wr_ctrl) begin
                st_d.ctrl.ie_chain = csr_wdata[CT_IE_CHAIN];
                st_d.ctrl.ie_glob  = csr_wdata[CT_IE_GLOB];
                st_d.ctrl.run      = csr_wdata[CT_RUN];
            end
            if (wr_ptr) st_d.ptr = csr_wdata[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign csr_rdata     = st_q.rdata;
    assign eng_run       = st_q.ctrl.run;
    assign eng_start_ptr = st_q.ptr;
    assign eng_reset     = rst_pulse;
    assign irq           = irq_w;
    assign unused_wdata  = ^csr_wdata;
endmodule

// File: rtl/sgdma_csr_chk.sv
`timescale 1ns/1ps
module sgdma_csr_chk #(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PTR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] csr_addr,
    input logic              csr_wr,
    input logic [DATA_W-1:0] csr_wdata,
    input logic              eng_run,
    input logic [PTR_W-1:0]  eng_start_ptr,
    input logic              eng_reset,
    input logic              chain_done,
    input logic              irq,
    input logic              ie_chain,
    input logic              ie_glob,
    input logic              armed,
    input logic              chain_flag
);
    logic wr_st, wr_ct, wr_pt, rst_wr;
    assign wr_st  = csr_wr && (csr_addr == ADDR_W'(0));
    assign wr_ct  = csr_wr && (csr_addr == ADDR_W'(1));
    assign wr_pt  = csr_wr && (csr_addr == ADDR_W'(2));
    assign rst_wr = wr_ct && csr_wdata[4] && armed;

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(chain_done && ie_chain && ie_glob));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_ct && (csr_wdata[3] || rst_wr)));

    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain_flag) |-> $past((wr_st && csr_wdata[1] && !chain_done) || rst_wr));

    p_run_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eng_run) |-> $past(wr_ct));

    p_ptr_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eng_start_ptr) |-> $past(wr_pt || rst_wr));

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |=> !eng_reset);

    p_pulse_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> (!eng_run && !irq && eng_start_ptr == '0));

    p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> $past(rst_wr));
endmodule

bind sgdma_csr sgdma_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_addr      (csr_addr),
    .csr_wr        (csr_wr),
    .csr_wdata     (csr_wdata),
    .eng_run       (eng_run),
    .eng_start_ptr (eng_start_ptr),
    .eng_reset     (eng_reset),
    .chain_done    (chain_done),
    .irq           (irq),
    .ie_chain      (st_q.ctrl.ie_chain),
    .ie_glob       (st_q.ctrl.ie_glob),
    .armed         (armed),
    .chain_flag    (flags[1])
);

// File: tb/sgdma_csr_tb.sv
`timescale 1ns/1ps
module sgdma_csr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  csr_addr = '0;
    logic        csr_wr = 1'b0, csr_rd = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        eng_run, eng_reset, irq;
    logic [31:0] eng_start_ptr;
    logic        desc_done = 1'b0, chain_done = 1'b0, eng_busy = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model of the register state
    logic [1:0]  m_flag;
    logic        m_iec, m_ieg, m_run, m_irq, m_arm, m_rst;
    logic [31:0] m_ptr;

    always #2.5 clk = ~clk;

    sgdma_csr u_dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
        .eng_run(eng_run), .eng_start_ptr(eng_start_ptr), .eng_reset(eng_reset),
        .desc_done(desc_done), .chain_done(chain_done), .eng_busy(eng_busy),
        .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] read_word(logic [1:0] a, logic busy);
        case (a)
            2'd0:    return {27'd0, busy, 2'b00, m_flag};
            2'd1:    return {29'd0, m_run, m_ieg, m_iec};
            2'd2:    return m_ptr;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(logic [1:0] a);
        case (a)
            2'd0:    return "R3 status read";
            2'd1:    return "R8 control read";
            2'd2:    return "R6 pointer read";
            default: return "R2 unmapped read";
        endcase
    endfunction

    // One clock cycle: drive at a falling edge, check at the next falling edge.
    task automatic cyc(bit wr, bit [1:0] a, bit [31:0] d, bit rd,
                       bit de, bit ce, bit busy);
        logic [31:0] exp_rd;
        logic        fire, wst, wct;
        exp_rd = read_word(a, busy);
        wst  = wr && a == 2'd0;
        wct  = wr && a == 2'd1;
        fire = wct && d[4] && m_arm;
        if (fire) begin
            m_flag = '0; m_iec = 0; m_ieg = 0; m_run = 0;
            m_ptr = '0; m_irq = 0; m_arm = 0;
        end else begin
            m_irq     = (ce && m_iec && m_ieg) || (m_irq && !(wct && d[3]));
            m_flag[0] = de || (m_flag[0] && !(wst && d[0]));
            m_flag[1] = ce || (m_flag[1] && !(wst && d[1]));
            if (wct) begin m_iec = d[0]; m_ieg = d[1]; m_run = d[2]; end
            if (wr && a == 2'd2) m_ptr = d;
            if (wr) m_arm = wct && d[4];
        end
        m_rst = fire;
        csr_wr = wr; csr_addr = a; csr_wdata = d; csr_rd = rd;
        desc_done = de; chain_done = ce; eng_busy = busy;
        @(negedge clk);
        chk("R8 irq level", {31'd0, irq}, {31'd0, m_irq});
        chk("R6 run level", {31'd0, eng_run}, {31'd0, m_run});
        chk("R6 start pointer", eng_start_ptr, m_ptr);
        chk("R9 reset pulse", {31'd0, eng_reset}, {31'd0, m_rst});
        if (rd) chk(rd_tag(a), csr_rdata, exp_rd);
        csr_wr = 0; csr_rd = 0; desc_done = 0; chain_done = 0;
    endtask

    task automatic wr(bit [1:0] a, bit [31:0] d);
        cyc(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic rd_chk(string tag, bit [1:0] a, bit busy, bit [31:0] exp);
        cyc(0, a, 0, 1, 0, 0, busy);
        chk(tag, csr_rdata, exp);
    endtask

    task automatic idle_cyc();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_flag = '0; m_iec = 0; m_ieg = 0; m_run = 0;
        m_ptr = '0; m_irq = 0; m_arm = 0; m_rst = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 run after reset", {31'd0, eng_run}, 32'd0);
        rd_chk("R1 status after reset", 2'd0, 0, 32'h0);
        rd_chk("R1 control after reset", 2'd1, 0, 32'h0);
        rd_chk("R1 pointer after reset", 2'd2, 0, 32'h0);

        // R2 unmapped offset ignores writes, reads zero
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk("R2 offset 3 reads zero", 2'd3, 0, 32'h0);
        rd_chk("R2 pointer untouched by offset 3", 2'd2, 0, 32'h0);

        // R5 busy mirror
        rd_chk("R5 busy high", 2'd0, 1, 32'h10);
        rd_chk("R5 busy low", 2'd0, 0, 32'h0);

        // R3 flag setting
        cyc(0, 0, 0, 0, 1, 0, 0);
        rd_chk("R3 descriptor flag", 2'd0, 0, 32'h1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        rd_chk("R3 both flags", 2'd0, 0, 32'h3);

        // R4 write-1-to-clear and collision
        wr(2'd0, 32'h0);
        rd_chk("R4 zero write keeps flags", 2'd0, 0, 32'h3);
        wr(2'd0, 32'h1);
        rd_chk("R4 clear bit 0 only", 2'd0, 0, 32'h2);
        cyc(1, 2'd0, 32'h2, 0, 0, 1, 0);
        rd_chk("R4 event wins over clear", 2'd0, 0, 32'h2);
        wr(2'd0, 32'h2);
        rd_chk("R4 chain flag cleared", 2'd0, 0, 32'h0);

        // R7 interrupt gating
        wr(2'd1, 32'h1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R7 no irq with chain enable only", {31'd0, irq}, 32'd0);
        wr(2'd1, 32'h2);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R7 no irq with global enable only", {31'd0, irq}, 32'd0);
        wr(2'd1, 32'h3);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R7 no irq from descriptor event", {31'd0, irq}, 32'd0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R7 irq raised", {31'd0, irq}, 32'd1);

        // R8 pending interrupt survives flag clears
        wr(2'd0, 32'h3);
        idle_cyc();
        chk("R8 irq held after flags cleared", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h0B);
        chk("R8 irq cleared", {31'd0, irq}, 32'd0);
        rd_chk("R8 clear bit reads zero", 2'd1, 0, 32'h3);

        // R6 run and pointer outputs
        wr(2'd2, 32'hDEAD_BEEF);
        wr(2'd1, 32'h7);
        chk("R6 run out", {31'd0, eng_run}, 32'd1);
        chk("R6 pointer out", eng_start_ptr, 32'hDEAD_BEEF);

        // R9 two consecutive reset writes
        wr(2'd1, 32'h17);
        chk("R9 single write no reset", {31'd0, eng_reset}, 32'd0);
        chk("R9 single write keeps run", {31'd0, eng_run}, 32'd1);
        wr(2'd1, 32'h17);
        chk("R9 reset pulse", {31'd0, eng_reset}, 32'd1);
        chk("R9 pointer zeroed", eng_start_ptr, 32'd0);
        idle_cyc();
        chk("R9 pulse one cycle", {31'd0, eng_reset}, 32'd0);
        rd_chk("R9 control zeroed", 2'd1, 0, 32'h0);

        // R10 interrupted sequence
        wr(2'd1, 32'h14);
        wr(2'd2, 32'h55);
        wr(2'd1, 32'h14);
        chk("R10 cancelled: no reset", {31'd0, eng_reset}, 32'd0);
        chk("R10 cancelled: pointer kept", eng_start_ptr, 32'h55);
        wr(2'd1, 32'h14);
        chk("R10 re-armed sequence fires", {31'd0, eng_reset}, 32'd1);

        // Constrained random traffic
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            bit [1:0]  a;
            bit [31:0] d;
            bit        w, r;
            a = 2'($urandom_range(0, 3));
            d = $urandom;
            if (a == 2'd1) begin
                d[4] = ($urandom_range(0, 3) == 0);
                d[3] = ($urandom_range(0, 2) == 0);
            end
            w = ($urandom_range(0, 2) == 0);
            r = ($urandom_range(0, 1) == 0);
            cyc(w, a, d, r, ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule